// File: doc/BRIEF.md
# Mirrored 8K-Space Chip-Select Decoder

This block turns a CPU address and a write strobe into chip selects for four devices in a small 8-bit system: a video/sound register block, a 128-byte RAM, an I/O-and-timer register block and a cartridge ROM. It is purely combinational. Next to each select it drives the local offset that the device needs.

Only a handful of address lines are decoded, so each device answers at many shadow addresses. The CPU produces 16-bit addresses, but only 13 lines leave the package. The upper three bits are therefore ignored, and the whole 8K map repeats eight times. In the lower 4K, a 1K pattern of video, RAM and I/O windows repeats four times. The upper 4K belongs to the cartridge. A 2K cartridge shows up twice in that 4K window.

Top module: `mirror_addr_decoder`

## Requirements
- R1: Address bits 15 to 13 have no effect on any select or offset output.
- R2: A read with address bit 12 set (4096 to 8191 within the 8K map) asserts only `rom_sel_o`.
- R3: `rom_ofs_o` equals the address modulo 2**ROM_AW. With ROM_AW=12 (4K cartridge) the window starts at offset 0 at 4096. With ROM_AW=11 (2K cartridge), 4096 to 6143 and 6144 to 8191 give the same offsets.
- R4: Within each 1K block of the lower 4K, `ram_sel_o` is set for 128 to 255 and 384 to 511. `ram_ofs_o` equals address bits 6:0, so both images reach the same byte.
- R5: Within each 1K block of the lower 4K, `io_sel_o` is set for 640 to 767 and 896 to 1023, and `io_ofs_o` equals address bits 4:0.
- R6: Within each 1K block of the lower 4K, `vid_sel_o` is set for 0 to 127, 256 to 383, 512 to 639 and 768 to 895. `vid_ofs_o` equals address bits 5:0, and the register set uses offsets 0 to 47.
- R7: The 1K pattern at 0 to 1023 repeats unchanged at 1024, 2048 and 3072.
- R8: At most one select is active for any input. In the lower 4K, exactly one is active.
- R9: A write (`wr_i`=1) with address bit 12 set asserts no select at all.
- R10: `wr_i` does not change the select or the offsets in the lower 4K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 16 | CPU address. Bits 15:13 are not decoded. |
| wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| vid_sel_o | output | 1 | Video/sound register block select |
| ram_sel_o | output | 1 | 128-byte RAM select |
| io_sel_o | output | 1 | I/O-and-timer block select |
| rom_sel_o | output | 1 | Cartridge ROM select (reads only) |
| vid_ofs_o | output | 6 | Register offset into the video block |
| ram_ofs_o | output | 7 | Byte offset into the RAM |
| io_ofs_o | output | 5 | Register offset into the I/O block |
| rom_ofs_o | output | ROM_AW | Byte offset into the cartridge |

## Verification
The bench sweeps all 65536 addresses twice, once as reads and once as writes. It compares every select and offset against a map built from the decimal ranges, not from the decoded bits. The full 16-bit sweep separates a decoder that wrongly looks at bits 15:13 or at bits 8, 10 and 11 from a correct one. The write pass separates the ROM write-blocking from the lower-4K decode, which must not depend on the strobe. A second instance built for a 2K cartridge shows whether the two halves of the cartridge window fold onto each other. Directed probes at the two RAM images and at the cartridge boundary confirm that shadow addresses reach the same byte.

// File: rtl/mirror_dec_pkg.sv
package mirror_dec_pkg;
    localparam int CPU_AW    = 16;  // internal address width
    localparam int BUS_AW    = 13;  // lines leaving the CPU package
    localparam int RAM_OW    = 7;   // 128 bytes
    localparam int IO_OW     = 5;   // 32-register window
    localparam int VID_OW    = 6;   // 48 registers inside a 64 slot
    localparam int CART_BIT  = 12;  // upper 4K -> cartridge
    localparam int SPLIT_BIT = 7;   // 0 -> video block
    localparam int IOSEL_BIT = 9;   // 0 -> RAM, 1 -> I/O

    typedef enum logic [2:0] {
        DEV_NONE,
        DEV_VID,
        DEV_RAM,
        DEV_IO,
        DEV_ROM
    } dev_e;

    typedef struct packed {
        logic vid;
        logic ram;
        logic io;
        logic rom;
    } sel_t;
endpackage

// File: rtl/mirror_dec_region.sv
module mirror_dec_region
    import mirror_dec_pkg::*;
(
    input  logic cart_bit_i,
    input  logic split_bit_i,
    input  logic iosel_bit_i,
    input  logic wr_i,
    output dev_e dev_o
);
    always_comb begin
        if (cart_bit_i) begin
            // the cartridge is read-only: a write selects nobody
            dev_o = wr_i ? DEV_NONE : DEV_ROM;
        end else if (!split_bit_i) begin
            dev_o = DEV_VID;
        end else if (!iosel_bit_i) begin
            dev_o = DEV_RAM;
        end else begin
            dev_o = DEV_IO;
        end
    end
endmodule

// File: rtl/mirror_dec_offsets.sv
module mirror_dec_offsets
    import mirror_dec_pkg::*;
#(
    parameter int ROM_AW = 12
) (
    input  logic [BUS_AW-1:0] bus_addr_i,
    output logic [VID_OW-1:0] vid_ofs_o,
    output logic [RAM_OW-1:0] ram_ofs_o,
    output logic [IO_OW-1:0]  io_ofs_o,
    output logic [ROM_AW-1:0] rom_ofs_o
);
    assign vid_ofs_o = bus_addr_i[VID_OW-1:0];
    assign ram_ofs_o = bus_addr_i[RAM_OW-1:0];
    assign io_ofs_o  = bus_addr_i[IO_OW-1:0];

    generate
        if (ROM_AW < CART_BIT) begin : g_small_cart
            // cartridge smaller than the window: upper lines fold it
            logic unused_fold;
            assign unused_fold = ^bus_addr_i[BUS_AW-1:ROM_AW];
            assign rom_ofs_o   = bus_addr_i[ROM_AW-1:0];
        end else begin : g_full_cart
            logic unused_cart_bit;
            assign unused_cart_bit = bus_addr_i[CART_BIT];
            assign rom_ofs_o       = bus_addr_i[CART_BIT-1:0];
        end
    endgenerate
endmodule

// File: rtl/mirror_addr_decoder.sv
module mirror_addr_decoder
    import mirror_dec_pkg::*;
#(
    parameter int ROM_AW = 12
) (
    input  logic [15:0]       addr_i,
    input  logic              wr_i,
    output logic              vid_sel_o,
    output logic              ram_sel_o,
    output logic              io_sel_o,
    output logic              rom_sel_o,
    output logic [5:0]        vid_ofs_o,
    output logic [6:0]        ram_ofs_o,
    output logic [4:0]        io_ofs_o,
    output logic [ROM_AW-1:0] rom_ofs_o
);
    logic [BUS_AW-1:0] bus_addr;
    logic              unused_hi_bits;
    dev_e              dev;
    sel_t              sel_d;

    // only the external lines take part in decoding
    assign bus_addr       = addr_i[BUS_AW-1:0];
    assign unused_hi_bits = ^addr_i[CPU_AW-1:BUS_AW];

    mirror_dec_region u_region (
        .cart_bit_i  (bus_addr[CART_BIT]),
        .split_bit_i (bus_addr[SPLIT_BIT]),
        .iosel_bit_i (bus_addr[IOSEL_BIT]),
        .wr_i        (wr_i),
        .dev_o       (dev)
    );

    mirror_dec_offsets #(.ROM_AW(ROM_AW)) u_offsets (
        .bus_addr_i (bus_addr),
        .vid_ofs_o  (vid_ofs_o),
        .ram_ofs_o  (ram_ofs_o),
        .io_ofs_o   (io_ofs_o),
        .rom_ofs_o  (rom_ofs_o)
    );

    always_comb begin
        sel_d = '0;
        unique case (dev)
            DEV_VID: sel_d.vid = 1'b1;
            DEV_RAM: sel_d.ram = 1'b1;
            DEV_IO:  sel_d.io  = 1'b1;
            DEV_ROM: sel_d.rom = 1'b1;
            default: sel_d     = '0;
        endcase
    end

    assign vid_sel_o = sel_d.vid;
    assign ram_sel_o = sel_d.ram;
    assign io_sel_o  = sel_d.io;
    assign rom_sel_o = sel_d.rom;
endmodule

module mirror_addr_decoder_chk (
    input logic [15:0] addr_i,
    input logic        wr_i,
    input logic        vid_sel_o,
    input logic        ram_sel_o,
    input logic        io_sel_o,
    input logic        rom_sel_o,
    input logic [6:0]  ram_ofs_o,
    input logic [4:0]  io_ofs_o
);
    always_comb begin
        a_r8_one_hot: assert ($onehot0({vid_sel_o, ram_sel_o, io_sel_o, rom_sel_o}))
            else $error("two selects active at %h", addr_i);
        a_r8_lower_covered: assert (addr_i[12] || $countones({vid_sel_o, ram_sel_o, io_sel_o, rom_sel_o}) == 1)
            else $error("lower 4K address %h without exactly one select", addr_i);
        a_r9_no_rom_write: assert (!(addr_i[12] && wr_i) || !(vid_sel_o || ram_sel_o || io_sel_o || rom_sel_o))
            else $error("select during cartridge write at %h", addr_i);
        a_r2_rom_read: assert (!(addr_i[12] && !wr_i) || rom_sel_o)
            else $error("cartridge read without ROM select at %h", addr_i);
        a_r4_ram_byte: assert (!ram_sel_o || ram_ofs_o == addr_i[6:0])
            else $error("RAM offset wrong at %h", addr_i);
        a_r5_io_window: assert (!io_sel_o || (addr_i[9] && addr_i[7] && io_ofs_o == addr_i[4:0]))
            else $error("I/O select or offset wrong at %h", addr_i);
    end
endmodule

bind mirror_addr_decoder mirror_addr_decoder_chk u_chk (
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .vid_sel_o (vid_sel_o),
    .ram_sel_o (ram_sel_o),
    .io_sel_o  (io_sel_o),
    .rom_sel_o (rom_sel_o),
    .ram_ofs_o (ram_ofs_o),
    .io_ofs_o  (io_ofs_o)
);

// File: tb/mirror_addr_decoder_tb.sv
module mirror_addr_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [15:0] addr = '0;
    logic        wr   = 1'b0;

    logic        vid, ram, io, rom;
    logic [5:0]  vid_ofs;
    logic [6:0]  ram_ofs;
    logic [4:0]  io_ofs;
    logic [11:0] rom_ofs;

    logic        vid2, ram2, io2, rom2;
    logic [5:0]  vid_ofs2;
    logic [6:0]  ram_ofs2;
    logic [4:0]  io_ofs2;
    logic [10:0] rom_ofs2;

    mirror_addr_decoder #(.ROM_AW(12)) dut_i (
        .addr_i(addr), .wr_i(wr),
        .vid_sel_o(vid), .ram_sel_o(ram), .io_sel_o(io), .rom_sel_o(rom),
        .vid_ofs_o(vid_ofs), .ram_ofs_o(ram_ofs), .io_ofs_o(io_ofs), .rom_ofs_o(rom_ofs)
    );

    mirror_addr_decoder #(.ROM_AW(11)) dut2k_i (
        .addr_i(addr), .wr_i(wr),
        .vid_sel_o(vid2), .ram_sel_o(ram2), .io_sel_o(io2), .rom_sel_o(rom2),
        .vid_ofs_o(vid_ofs2), .ram_ofs_o(ram_ofs2), .io_ofs_o(io_ofs2), .rom_ofs_o(rom_ofs2)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input int act, input int exp, input int a);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s addr=%0d wr=%0b actual=%0d expected=%0d", req, a, wr, act, exp);
        end
    endtask

    // reference map from decimal ranges; sel code: 8=vid 4=ram 2=io 1=rom
    function automatic int ref_sel(input int a, input bit w);
        int b = a % 8192;
        int m = b % 1024;
        if (b >= 4096) return w ? 0 : 1;
        if (m < 128 || (m >= 256 && m < 384) || (m >= 512 && m < 640) ||
            (m >= 768 && m < 896)) return 8;
        if ((m >= 128 && m < 256) || (m >= 384 && m < 512)) return 4;
        return 2;
    endfunction

    function automatic string sel_req(input int a, input bit w);
        int b = a % 8192;
        int s = ref_sel(a, w);
        if (b >= 4096) return w ? "R9" : "R2";
        if (a >= 8192) return "R1";
        if (b >= 1024) return "R7";
        if (w) return "R10";
        return (s == 8) ? "R6" : (s == 4) ? "R4" : "R5";
    endfunction

    task automatic sweep(input bit w);
        for (int a = 0; a < 65536; a++) begin
            int b = a % 8192;
            int m = b % 1024;
            int es = ref_sel(a, w);
            addr = a[15:0];
            wr   = w;
            #2;
            check(sel_req(a, w), {28'd0, vid, ram, io, rom}, es, a);
            if (es == 8) check("R6", vid_ofs, m % 64, a);
            if (es == 4) check("R4", ram_ofs, (m < 256) ? m - 128 : m - 384, a);
            if (es == 2) check("R5", io_ofs, (m < 896) ? (m - 640) % 32 : (m - 896) % 32, a);
            if (es == 1) begin
                check("R3", rom_ofs, b - 4096, a);
                check("R3", rom_ofs2, (b - 4096) % 2048, a);
            end
            check("R8", {28'd0, vid2, ram2, io2, rom2}, es, a);
        end
    endtask

    task automatic probe(input int a, input bit w);
        addr = a[15:0];
        wr   = w;
        #2;
    endtask

    initial begin
        int first_ofs;
        #1;
        // state at time zero: address 0, read -> video block, offset 0
        check("R6", {28'd0, vid, ram, io, rom}, 8, 0);
        check("R6", vid_ofs, 0, 0);

        // R4: two RAM images reach the same byte
        probe(128 + 37, 1'b0);
        first_ofs = ram_ofs;
        probe(384 + 37, 1'b1);
        check("R4", ram_ofs, first_ofs, 384 + 37);
        check("R4", ram, 1, 384 + 37);

        // R3: 2K cartridge halves fold together
        probe(4096 + 5, 1'b0);
        first_ofs = rom_ofs2;
        probe(6144 + 5, 1'b0);
        check("R3", rom_ofs2, first_ofs, 6144 + 5);
        check("R3", rom_ofs, 2048 + 5, 6144 + 5);

        // R9: cartridge write selects nothing, then read selects ROM
        probe(8191, 1'b1);
        check("R9", {28'd0, vid, ram, io, rom}, 0, 8191);
        probe(8191, 1'b0);
        check("R2", rom, 1, 8191);

        // R1: highest mirror of the I/O window
        probe(57344 + 640, 1'b0);
        check("R1", io, 1, 57344 + 640);

        sweep(1'b0);
        sweep(1'b1);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule